// File: doc/BRIEF.md
# Hierarchical Crosswise Squarer

This block returns the unsigned square of a wide operand. Its core is a general unsigned multiplier built by recursion. The smallest piece is a 2-bit by 2-bit cell. That cell forms its outer result columns from the straight-down bit products. Its middle column adds the two diagonal bit products, and each carry passes leftward to the next column.

Each level above the leaf splits both operands into a high half and a low half. It computes the four half-width products in parallel and lays them out as three overlapping rows: the low-by-low and high-by-high products side by side in one row, and the two mixed products shifted up by half the width. A single carry-save stage reduces the three rows to two, and one carry-propagate adder closes the level. The top ties both multiplier inputs to the same operand. When selected, an output register holds the result for timing closure.

Top module: `vcx_square`

## Requirements
- R1: The 2x2 leaf gives a*b for all 16 operand pairs. Bit 0 is a0&b0. Bit 1 is the low bit of (a1&b0)+(a0&b1). Bit 2 is a1&b1 plus the carry from bit 1. Bit 3 is the carry out of bit 2.
- R2: At every level of width n, the product equals LL + ((HL + LH) << n/2) + (HH << n), where H and L are the high and low n/2-bit halves of each operand. This holds exhaustively at n = 4 and n = 8.
- R3: The multiplier gives the exact 2n-bit unsigned product for arbitrary, unequal operands at widths 16 and 32.
- R4: The top output equals operand*operand, unsigned, for every input. This includes zero, all-ones (0xFFFFFFFF gives 0xFFFFFFFE00000001), a lone top bit and single-bit powers.
- R5: Bit 0 of the square equals bit 0 of the operand, and bit 1 of the square is always 0.
- R6: With OUT_REG=1, the square of the operand sampled at a rising clock edge appears at the output just after that edge and holds until the next edge. With OUT_REG=0, the output follows the operand with no clock.
- R7: With OUT_REG=1, driving rst_n low clears the output to zero at once, with no clock edge needed, and the output stays zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| operand | input | WIDTH | Unsigned value to square |
| square | output | 2*WIDTH | Unsigned square of operand |

## Verification
The difficult part is the carry that crosses between levels. A fault in the carry-save stage or in a mid-level adder may show up only when the mixed products and the high product overlap with carries set in many columns. Squares of random values rarely produce that pattern, and they never test unequal operands.

The bench therefore drives the inner levels directly as general multipliers. It sweeps the 4-bit and 8-bit levels over every operand pair, including the all-ones against all-ones case, then runs random unequal pairs at 16 and 32 bits. After that it exercises the squarer itself with corner values and random values, both through the register and without it.

// File: rtl/vcx_pkg.sv
`timescale 1ns/1ps
package vcx_pkg;
  // legal operand widths: powers of two, two or more
  function automatic bit vcx_width_ok(int unsigned w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction
endpackage

// File: rtl/vcx_leaf2.sv
`timescale 1ns/1ps
module vcx_leaf2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic col0;
  logic x10, x01, col1_s, col1_k;
  logic v11, col2_s, col2_k;

  always_comb begin
    // rightmost column: straight product, carry in is zero
    col0   = a[0] & b[0];
    // middle column: the two crosswise products
    x10    = a[1] & b[0];
    x01    = a[0] & b[1];
    col1_s = x10 ^ x01;
    col1_k = x10 & x01;
    // left column: straight product plus carry from the middle
    v11    = a[1] & b[1];
    col2_s = v11 ^ col1_k;
    col2_k = v11 & col1_k;
    p      = {col2_k, col2_s, col1_s, col0};
  end
endmodule

// File: rtl/vcx_csa.sv
`timescale 1ns/1ps
module vcx_csa #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] z,
  output logic [N-1:0] sum,
  output logic [N-1:0] cy
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ z[i];
    assign cy[i]  = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end
endmodule

// File: rtl/vcx_mul.sv
`timescale 1ns/1ps
module vcx_mul #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned HW = W / 2;

  if (!vcx_pkg::vcx_width_ok(W)) begin : g_bad_width
    $error("vcx_mul: width must be a power of two of at least 2");
  end

  if (W == 2) begin : g_leaf
    vcx_leaf2 u_leaf (.a(a), .b(b), .p(p));
  end else begin : g_split
    logic [HW-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [W-1:0]  p_ll, p_lh, p_hl, p_hh;
    logic [PW-1:0] row_outer, row_mix0, row_mix1;
    logic [PW-1:0] rs, rc;

    assign a_lo = a[HW-1:0];
    assign a_hi = a[W-1:HW];
    assign b_lo = b[HW-1:0];
    assign b_hi = b[W-1:HW];

    vcx_mul #(.W(HW)) u_ll (.a(a_lo), .b(b_lo), .p(p_ll));
    vcx_mul #(.W(HW)) u_lh (.a(a_lo), .b(b_hi), .p(p_lh));
    vcx_mul #(.W(HW)) u_hl (.a(a_hi), .b(b_lo), .p(p_hl));
    vcx_mul #(.W(HW)) u_hh (.a(a_hi), .b(b_hi), .p(p_hh));

    // outer products do not overlap: one row; mixed products shifted by HW
    always_comb begin
      row_outer = {p_hh, p_ll};
      row_mix0  = {{HW{1'b0}}, p_lh, {HW{1'b0}}};
      row_mix1  = {{HW{1'b0}}, p_hl, {HW{1'b0}}};
    end

    vcx_csa #(.N(PW)) u_csa (
      .x(row_outer), .y(row_mix0), .z(row_mix1), .sum(rs), .cy(rc)
    );

    // single carry-propagate adder closes the level; top carry cannot be set
    assign p = rs + {rc[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/vcx_square.sv
`timescale 1ns/1ps
module vcx_square #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIDTH-1:0]     operand,
  output logic [2*WIDTH-1:0]   square
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0] sq_nxt;

  vcx_mul #(.W(WIDTH)) u_mul (.a(operand), .b(operand), .p(sq_nxt));

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] sq_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq_q <= '0;
      else        sq_q <= sq_nxt;
    end
    assign square = sq_q;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk ^ rst_n;
    assign square    = sq_nxt;
  end
endmodule

// File: rtl/vcx_square_chk.sv
`timescale 1ns/1ps
module vcx_square_chk #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WIDTH-1:0]   operand,
  input logic [2*WIDTH-1:0] square
);
  localparam int unsigned PW = 2 * WIDTH;
  localparam logic [PW-1:0] ONES_SQ =
    {{(WIDTH-1){1'b1}}, 1'b0, {(WIDTH-1){1'b0}}, 1'b1};

  logic [PW-1:0] ref_sq;
  assign ref_sq = PW'(operand) * PW'(operand);

  if (OUT_REG) begin : g_reg
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> square == $past(ref_sq));
    a_r5_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> square[1:0] == {1'b0, $past(operand[0])});
    a_r4_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (operand == '1) |=> square == ONES_SQ);
    a_r7_reset_clears: assert property (@(posedge clk)
      !rst_n |-> square == '0);
  end else begin : g_comb
    a_r4_exact: assert property (@(posedge clk) disable iff (!rst_n)
      square == ref_sq);
    a_r5_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      square[1:0] == {1'b0, operand[0]});
    a_r6_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(operand) |-> $stable(square));
  end
endmodule

bind vcx_square vcx_square_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) chk_i (.*);

// File: tb/vcx_square_tb_top.sv
`timescale 1ns/1ps
module vcx_square_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] op_r, op_c;
  logic [63:0] sq_r, sq_c;
  logic [1:0]  a2, b2;   logic [3:0]  p2;
  logic [3:0]  a4, b4;   logic [7:0]  p4;
  logic [7:0]  a8, b8;   logic [15:0] p8;
  logic [15:0] a16, b16; logic [31:0] p16;
  logic [31:0] a32, b32; logic [63:0] p32;

  vcx_square #(.WIDTH(32), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .operand(op_r), .square(sq_r));
  vcx_square #(.WIDTH(32), .OUT_REG(1'b0)) comb_i (
    .clk(clk), .rst_n(rst_n), .operand(op_c), .square(sq_c));
  vcx_mul #(.W(2))  m2_i  (.a(a2),  .b(b2),  .p(p2));
  vcx_mul #(.W(4))  m4_i  (.a(a4),  .b(b4),  .p(p4));
  vcx_mul #(.W(8))  m8_i  (.a(a8),  .b(b8),  .p(p8));
  vcx_mul #(.W(16)) m16_i (.a(a16), .b(b16), .p(p16));
  vcx_mul #(.W(32)) m32_i (.a(a32), .b(b32), .p(p32));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sq64(input logic [31:0] v);
    return 64'(v) * 64'(v);
  endfunction

  // registered path: drive after falling edge, check at next falling edge
  task automatic reg_case(input logic [31:0] v);
    @(negedge clk);
    op_r = v;
    @(negedge clk);
    chk("R4/R6 registered square", sq_r, sq64(v));
    chk("R5 low bits", 64'(sq_r[1:0]), 64'({1'b0, v[0]}));
  endtask

  task automatic comb_case(input logic [31:0] v);
    op_c = v;
    #1;
    chk("R4/R6 combinational square", sq_c, sq64(v));
  endtask

  logic [31:0] corners [8];

  initial begin
    op_r = 32'hFFFF_FFFF; op_c = '0;
    a2 = '0; b2 = '0; a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    a16 = '0; b16 = '0; a32 = '0; b32 = '0;
    corners[0] = 32'h0;         corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'h0001_0000;
    corners[4] = 32'h1;         corners[5] = 32'h0000_FFFF;
    corners[6] = 32'hAAAA_AAAA; corners[7] = 32'h5555_5555;

    // R7: output zero while in reset, with a nonzero operand present
    repeat (3) @(negedge clk);
    chk("R7 reset state", sq_r, 64'h0);
    rst_n = 1'b1;

    // R1: leaf exhaustive
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        a2 = 2'(i); b2 = 2'(j); #1;
        chk("R1 leaf 2x2", 64'(p2), 64'(i * j));
      end

    // R2: 4-bit and 8-bit levels exhaustive
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        a4 = 4'(i); b4 = 4'(j); #1;
        chk("R2 level 4", 64'(p4), 64'(i * j));
      end
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++) begin
        a8 = 8'(i); b8 = 8'(j); #1;
        chk("R2 level 8", 64'(p8), 64'(i * j));
      end

    // R3: unequal operands at 16 and 32 bits, including extremes
    a16 = 16'hFFFF; b16 = 16'hFFFF; a32 = '1; b32 = '1; #1;
    chk("R3 level 16 ones", 64'(p16), 64'h0000_0000_FFFE_0001);
    chk("R3 level 32 ones", p32, 64'hFFFF_FFFE_0000_0001);
    for (int k = 0; k < 3000; k++) begin
      a16 = 16'($urandom); b16 = 16'($urandom);
      a32 = $urandom; b32 = $urandom; #1;
      chk("R3 level 16", 64'(p16), 64'(a16) * 64'(b16));
      chk("R3 level 32", p32, 64'(a32) * 64'(b32));
    end

    // R4/R5/R6 combinational top
    chk("R4 all ones constant", sq64(32'hFFFF_FFFF), 64'hFFFF_FFFE_0000_0001);
    for (int k = 0; k < 8; k++) comb_case(corners[k]);
    for (int k = 0; k < 32; k++) comb_case(32'h1 << k);
    for (int k = 0; k < 3000; k++) begin
      comb_case($urandom);
      chk("R5 bit1 zero", 64'(sq_c[1]), 64'h0);
    end

    // R4/R5/R6 registered top
    for (int k = 0; k < 8; k++) reg_case(corners[k]);
    for (int k = 0; k < 1500; k++) reg_case($urandom);

    // R6: output holds between edges even when operand changes
    @(negedge clk); op_r = 32'h1234_5678;
    @(negedge clk); op_r = 32'h0000_0003; #2;
    chk("R6 hold between edges", sq_r, sq64(32'h1234_5678));

    // R7: asynchronous clear between edges
    @(negedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R7 async clear", sq_r, 64'h0);
    @(negedge clk);
    chk("R7 held in reset", sq_r, 64'h0);
    rst_n = 1'b1;
    reg_case(32'hFFFF_FFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule